// File: doc/BRIEF.md
# Mailbox SPI Passthrough Bridge

This block lets a host reach an external SPI flash without driving the SPI pins itself. The host sees two byte-wide I/O ports: an index port at a configurable base address and a data port one address above it. The index port picks one register of a small mailbox, and the data port reads or writes that register. The mailbox holds a command register, an extended command register and fourteen data registers.

To issue a command, the host fills the data registers and then writes a nonzero code to the command register. The bridge runs the command, puts any result in data register 0 and then writes zero to the command register. The host polls that register to learn when the command is done. Raw SPI work is locked behind a passthrough mode. The host unlocks it by sending two ASCII keywords, the enter word and then the start word. After that, each mailbox command drives the chip select or moves exactly one byte over a mode-0 SPI link. A third keyword leaves the mode. Four further codes set and clear two enable flags, which other logic reads as outputs.

The controller has three states. `ST_IDLE` waits for a pending command and executes it. From `ST_IDLE`, a byte transfer in the started mode goes to `ST_SHIFT`, and every other command goes to `ST_RETIRE`. `ST_SHIFT` waits for the shifter to report its last SCLK edge and then goes to `ST_RETIRE`. `ST_RETIRE` clears the command register and returns to `ST_IDLE`. The passthrough mode has three states of its own: `PT_OFF`, `PT_ARMED` (enter word seen) and `PT_LIVE` (start word seen).

Top module: `mbx_spi_bridge`

## Requirements
- R1: A write to address BASE sets the mailbox index, and a read of BASE returns that index. The data port at BASE+1 reads and writes the register the index selects. The command register is at offset 0x82, the extended command register at 0x83, and data registers 0 to 13 at 0x84 to 0x91. Any other offset reads as 0x00 and ignores writes. After reset the index is 0x00.
- R2: A nonzero command register means the bridge is busy. The bridge writes 0x00 to it when the command completes. While it is busy, host writes to any mailbox register are dropped, but index writes still take effect. An unknown command code completes and changes nothing.
- R3: Command 0x55 with the data registers starting with the bytes "PathThruMode" moves the mode to armed from any mode and writes 0xAA to data register 0.
- R4: Command 0x55 with the data registers starting with "Start" moves the mode to started if it was armed or started, and writes 0xAA to data register 0. Otherwise it writes 0xFE and the mode does not change.
- R5: Command 0x55 with the data registers starting with "End_Mode" moves the mode to off from any mode, releases chip select and writes 0xAA to data register 0. From off, it is harmless and still reports 0xAA.
- R6: Command 0x55 with data that matches no keyword writes 0xFE to data register 0 and leaves the mode unchanged.
- R7: In the started mode, command 0xF0 drives spi_cs_n low and 0xF1 drives it high. After reset, spi_cs_n is high.
- R8: In the started mode, command 0xF2 shifts data register 0 out on spi_mosi, MSB first, in SPI mode 0. SCLK idles low, MOSI changes only while SCLK is low, and there are exactly 8 rising edges per byte.
- R9: In the started mode, command 0xF3 runs 8 SCLK cycles with spi_mosi held low, samples spi_miso on each rising edge, MSB first, and writes the byte to data register 0.
- R10: Outside the started mode, commands 0xF0 to 0xF3 have no effect: no SCLK edge, no chip-select change and no change to data register 0. The command register is cleared within two cycles.
- R11: For a byte transfer, the command register is cleared only after the last SCLK edge. SCLK toggles every CLK_DIV clocks, so a transfer takes 16*CLK_DIV clocks.
- R12: Commands 0x84 and 0x85 set and clear smi_en. Commands 0x86 and 0x87 set and clear acpi_en. Both flags are 1 after reset.
- R13: Any number of byte commands can be issued in the started mode without leaving it. Each one behaves as in R8 and R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | 16 | Host I/O address |
| host_wr | input | 1 | One-cycle host write strobe |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, combinational from host_addr |
| spi_sclk | output | 1 | SPI clock, idles low |
| spi_cs_n | output | 1 | SPI chip select, active low |
| spi_mosi | output | 1 | SPI data to the flash |
| spi_miso | input | 1 | SPI data from the flash |
| smi_en | output | 1 | SMI enable flag |
| acpi_en | output | 1 | ACPI enable flag |

## Verification
The assertions assume that the host raises host_wr for one clock per access. They also assume that spi_miso changes only after falling SCLK edges and that CLK_DIV is at least one. The command-register assertions further assume that the host writes a new command only after it has seen the previous one cleared. The bench always polls the command register to zero before its next command. It drives the host bus on falling clock edges, and its flash model updates MISO on falling SCLK edges, so every input keeps to these rules.

// File: rtl/mbxb_pkg.sv
package mbxb_pkg;
    // Mailbox offsets; the host decodes these, so they are fixed.
    localparam logic [7:0] OFS_CMD = 8'h82;
    localparam logic [7:0] OFS_EXT = 8'h83;
    localparam logic [7:0] OFS_D0  = 8'h84;
    localparam int         NDATA   = 14;
    localparam int         DW      = $clog2(NDATA);
    localparam int         KW_MAX  = 12;

    localparam logic [7:0] C_KEYWORD  = 8'h55;
    localparam logic [7:0] C_SMI_ON   = 8'h84;
    localparam logic [7:0] C_SMI_OFF  = 8'h85;
    localparam logic [7:0] C_ACPI_ON  = 8'h86;
    localparam logic [7:0] C_ACPI_OFF = 8'h87;
    localparam logic [7:0] C_CS_ON    = 8'hF0;
    localparam logic [7:0] C_CS_OFF   = 8'hF1;
    localparam logic [7:0] C_TX       = 8'hF2;
    localparam logic [7:0] C_RX       = 8'hF3;
    localparam logic [7:0] R_OK       = 8'hAA;
    localparam logic [7:0] R_BAD      = 8'hFE;

    typedef enum logic [1:0] {KW_NONE, KW_ENTER, KW_START, KW_EXIT} kw_e;
    typedef enum logic [1:0] {PT_OFF, PT_ARMED, PT_LIVE} pt_e;
    typedef enum logic [1:0] {ST_IDLE, ST_SHIFT, ST_RETIRE} st_e;
endpackage

// File: rtl/mbxb_kw_match.sv
module mbxb_kw_match import mbxb_pkg::*; (
    input  logic [8*NDATA-1:0] data_flat,
    output kw_e                kw
);
    // Keywords left-aligned in a KW_MAX-byte field; byte i sits at the top minus 8*i.
    localparam logic [8*KW_MAX-1:0] W_ENTER = "PathThruMode";
    localparam logic [8*KW_MAX-1:0] W_START = {"Start", 56'd0};
    localparam logic [8*KW_MAX-1:0] W_EXIT  = {"End_Mode", 32'd0};

    function automatic logic prefix_eq(input logic [8*KW_MAX-1:0] w, input int len,
                                       input logic [8*NDATA-1:0] d);
        logic ok;
        ok = 1'b1;
        for (int i = 0; i < KW_MAX; i++) begin
            if (i < len && d[8*i +: 8] != w[8*KW_MAX-1-8*i -: 8]) ok = 1'b0;
        end
        return ok;
    endfunction

    always_comb begin
        if (prefix_eq(W_ENTER, 12, data_flat))     kw = KW_ENTER;
        else if (prefix_eq(W_START, 5, data_flat)) kw = KW_START;
        else if (prefix_eq(W_EXIT, 8, data_flat))  kw = KW_EXIT;
        else                                       kw = KW_NONE;
    end
endmodule

// File: rtl/mbxb_spi_shift.sv
module mbxb_spi_shift #(
    parameter int CLK_DIV = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] tx,
    input  logic       miso,
    output logic       sclk,
    output logic       mosi,
    output logic       done,
    output logic [7:0] rx
);
    localparam int CW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(CLK_DIV - 1);

    logic          busy;
    logic [CW-1:0] cnt;
    logic [3:0]    edges;
    logic [7:0]    sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            sclk  <= 1'b0;
            cnt   <= '0;
            edges <= '0;
            sh    <= '0;
            rx    <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (start) begin
                    busy  <= 1'b1;
                    sh    <= tx;
                    cnt   <= '0;
                    edges <= '0;
                end
            end else if (cnt == CNT_LAST) begin
                cnt   <= '0;
                sclk  <= ~sclk;
                edges <= edges + 4'd1;
                if (!sclk) rx <= {rx[6:0], miso};   // rising edge: sample
                else       sh <= {sh[6:0], 1'b0};   // falling edge: next bit
                if (edges == 4'd15) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assign mosi = sh[7];
endmodule

// File: rtl/mbx_spi_bridge.sv
module mbx_spi_bridge import mbxb_pkg::*; #(
    parameter logic [15:0] BASE    = 16'h0A00,
    parameter int          CLK_DIV = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [15:0] host_addr,
    input  logic        host_wr,
    input  logic [7:0]  host_wdata,
    output logic [7:0]  host_rdata,
    output logic        spi_sclk,
    output logic        spi_cs_n,
    output logic        spi_mosi,
    input  logic        spi_miso,
    output logic        smi_en,
    output logic        acpi_en
);
    localparam logic [15:0] PORT_DATA = BASE + 16'd1;

    logic [7:0]        idx_q, cmd_q, ext_q;
    logic [7:0]        dreg [NDATA];
    logic [8*NDATA-1:0] data_flat;
    pt_e               mode_q;
    st_e               state_q, state_d;
    logic              cs_n_q, smi_q, acpi_q;
    kw_e               kw;
    logic              busy, exec, spi_go, in_data, sh_done;
    logic [DW-1:0]     didx;
    logic [7:0]        sh_rx;

    for (genvar g = 0; g < NDATA; g++) begin : g_flat
        assign data_flat[8*g +: 8] = dreg[g];
    end

    mbxb_kw_match u_kw (.data_flat(data_flat), .kw(kw));

    assign busy    = (cmd_q != 8'h00);
    assign exec    = (state_q == ST_IDLE) && busy;
    assign spi_go  = exec && (mode_q == PT_LIVE) && (cmd_q == C_TX || cmd_q == C_RX);
    assign in_data = (idx_q >= OFS_D0) && (idx_q < OFS_D0 + 8'(NDATA));
    assign didx    = DW'(idx_q - OFS_D0);

    mbxb_spi_shift #(.CLK_DIV(CLK_DIV)) u_shift (
        .clk(clk), .rst_n(rst_n), .start(spi_go),
        .tx((cmd_q == C_TX) ? dreg[0] : 8'h00),
        .miso(spi_miso), .sclk(spi_sclk), .mosi(spi_mosi),
        .done(sh_done), .rx(sh_rx)
    );

    // Host read path
    always_comb begin
        host_rdata = 8'h00;
        if (host_addr == BASE) host_rdata = idx_q;
        else if (host_addr == PORT_DATA) begin
            if (idx_q == OFS_CMD)      host_rdata = cmd_q;
            else if (idx_q == OFS_EXT) host_rdata = ext_q;
            else if (in_data)          host_rdata = dreg[didx];
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (exec) state_d = spi_go ? ST_SHIFT : ST_RETIRE;
            ST_SHIFT:  if (sh_done) state_d = ST_RETIRE;
            ST_RETIRE: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Mailbox, mode and flag updates
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q  <= '0;
            cmd_q  <= '0;
            ext_q  <= '0;
            mode_q <= PT_OFF;
            cs_n_q <= 1'b1;
            smi_q  <= 1'b1;
            acpi_q <= 1'b1;
            for (int i = 0; i < NDATA; i++) dreg[i] <= '0;
        end else begin
            if (host_wr && host_addr == BASE) idx_q <= host_wdata;
            if (host_wr && host_addr == PORT_DATA && !busy) begin
                if (idx_q == OFS_CMD)      cmd_q <= host_wdata;
                else if (idx_q == OFS_EXT) ext_q <= host_wdata;
                else if (in_data)          dreg[didx] <= host_wdata;
            end
            if (exec) begin
                case (cmd_q)
                    C_KEYWORD: begin
                        unique case (kw)
                            KW_ENTER: begin mode_q <= PT_ARMED; dreg[0] <= R_OK; end
                            KW_START: begin
                                if (mode_q != PT_OFF) begin
                                    mode_q  <= PT_LIVE;
                                    dreg[0] <= R_OK;
                                end else dreg[0] <= R_BAD;
                            end
                            KW_EXIT:  begin mode_q <= PT_OFF; cs_n_q <= 1'b1; dreg[0] <= R_OK; end
                            KW_NONE:  dreg[0] <= R_BAD;
                        endcase
                    end
                    C_CS_ON:    if (mode_q == PT_LIVE) cs_n_q <= 1'b0;
                    C_CS_OFF:   if (mode_q == PT_LIVE) cs_n_q <= 1'b1;
                    C_SMI_ON:   smi_q  <= 1'b1;
                    C_SMI_OFF:  smi_q  <= 1'b0;
                    C_ACPI_ON:  acpi_q <= 1'b1;
                    C_ACPI_OFF: acpi_q <= 1'b0;
                    default: ;
                endcase
            end
            if (state_q == ST_SHIFT && sh_done && cmd_q == C_RX) dreg[0] <= sh_rx;
            if (state_q == ST_RETIRE) cmd_q <= 8'h00;
        end
    end

    assign spi_cs_n = cs_n_q;
    assign smi_en   = smi_q;
    assign acpi_en  = acpi_q;
endmodule

// File: rtl/mbxb_chk.sv
module mbxb_chk import mbxb_pkg::*; (
    input logic       clk,
    input logic       rst_n,
    input logic       sclk,
    input logic       mosi,
    input logic       smi,
    input logic       acpi,
    input st_e        state,
    input pt_e        mode,
    input logic [7:0] cmd
);
    assert_sclk_low_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_IDLE |-> !sclk);

    assert_mosi_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(mosi));

    assert_sclk_in_shift_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sclk) |-> state == ST_SHIFT);

    assert_sclk_needs_live_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk) |-> mode == PT_LIVE);

    assert_cmd_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd != 8'h00 && state != ST_RETIRE) |=> cmd == $past(cmd));

    assert_cmd_cleared_R2: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_RETIRE |=> cmd == 8'h00);

    assert_smi_by_cmd_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(smi) |-> $past(state == ST_IDLE && (cmd == C_SMI_ON || cmd == C_SMI_OFF)));

    assert_acpi_by_cmd_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(acpi) |-> $past(state == ST_IDLE && (cmd == C_ACPI_ON || cmd == C_ACPI_OFF)));
endmodule

bind mbx_spi_bridge mbxb_chk u_chk (
    .clk(clk), .rst_n(rst_n), .sclk(spi_sclk), .mosi(spi_mosi),
    .smi(smi_en), .acpi(acpi_en), .state(state_q), .mode(mode_q), .cmd(cmd_q)
);

// File: tb/tb_mbx_spi_bridge.sv
module tb_mbx_spi_bridge;
    localparam logic [15:0] BASE = 16'h0A00;
    localparam logic [15:0] DPORT = BASE + 16'd1;
    localparam int DIV = 2;
    localparam logic [7:0] CMD = 8'h82, EXT = 8'h83, D0 = 8'h84;

    logic clk = 1'b0, rst_n;
    logic [15:0] host_addr;
    logic host_wr;
    logic [7:0] host_wdata, host_rdata;
    logic spi_sclk, spi_cs_n, spi_mosi, spi_miso, smi_en, acpi_en;

    int checks = 0, errors = 0, sclk_rises = 0, nbits = 0;
    bit finished = 1'b0;
    logic [7:0] exp_q [$];
    logic [7:0] slv_tx = 8'h00, slv_rx = 8'h00;
    logic [2:0] slv_bit = 3'd0;

    always #5 clk = ~clk;

    mbx_spi_bridge #(.BASE(BASE), .CLK_DIV(DIV)) dut (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .spi_sclk(spi_sclk),
        .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
        .smi_en(smi_en), .acpi_en(acpi_en)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Flash model: MISO moves on falling SCLK, MOSI captured on rising SCLK.
    assign spi_miso = slv_tx[~slv_bit];
    always @(negedge spi_sclk) slv_bit <= slv_bit + 3'd1;

    // Monitor: pop the expected MOSI byte after every 8 rising edges (R8)
    always @(posedge spi_sclk) begin
        sclk_rises++;
        slv_rx = {slv_rx[6:0], spi_mosi};
        nbits++;
        if (nbits == 8) begin
            nbits = 0;
            if (exp_q.size() == 0) chk("R8 unexpected MOSI byte", {24'd0, slv_rx}, 32'hFFFF_FFFF);
            else chk("R8 MOSI byte", {24'd0, slv_rx}, {24'd0, exp_q.pop_front()});
        end
    end

    task automatic hw(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk); host_addr = a; host_wr = 1'b1; host_wdata = d;
        @(negedge clk); host_wr = 1'b0;
    endtask

    task automatic hr(input logic [15:0] a, output logic [7:0] d);
        @(negedge clk); host_addr = a; #1; d = host_rdata;
    endtask

    task automatic mw(input logic [7:0] off, input logic [7:0] d);
        hw(BASE, off); hw(DPORT, d);
    endtask

    task automatic mr(input logic [7:0] off, output logic [7:0] d);
        hw(BASE, off); hr(DPORT, d);
    endtask

    task automatic wait_idle(output int n);
        logic [7:0] v;
        hw(BASE, CMD);
        n = 0;
        do begin hr(DPORT, v); n++; end while (v != 8'h00 && n < 5000);
        if (v != 8'h00) chk("R2 command never cleared", {24'd0, v}, 0);
    endtask

    task automatic docmd(input logic [7:0] code, output int n);
        logic [7:0] v;
        mw(CMD, code);
        n = 0;
        do begin hr(DPORT, v); n++; end while (v != 8'h00 && n < 5000);
        if (v != 8'h00) chk("R2 command never cleared", {24'd0, v}, 0);
    endtask

    task automatic keyword(input string s, output logic [7:0] res);
        int n;
        for (int i = 0; i < s.len(); i++) mw(D0 + 8'(i), s[i]);
        docmd(8'h55, n);
        mr(D0, res);
    endtask

    initial begin
        logic [7:0] v;
        int n, r0;
        rst_n = 1'b0; host_addr = '0; host_wr = 1'b0; host_wdata = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        hr(BASE, v);  chk("R1 reset index", {24'd0, v}, 0);
        hr(DPORT, v); chk("R1 unmapped offset 0 reads zero", {24'd0, v}, 0);
        chk("R12 smi_en after reset", {31'd0, smi_en}, 1);
        chk("R12 acpi_en after reset", {31'd0, acpi_en}, 1);
        chk("R7 cs_n after reset", {31'd0, spi_cs_n}, 1);
        chk("R8 sclk idle low", {31'd0, spi_sclk}, 0);

        mw(8'h85, 8'h3C); mr(8'h85, v); chk("R1 data reg readback", {24'd0, v}, 32'h3C);
        hr(BASE, v); chk("R1 index readback", {24'd0, v}, 32'h85);
        mw(8'h10, 8'h99); mr(8'h10, v); chk("R1 unmapped write ignored", {24'd0, v}, 0);
        mw(EXT, 8'h5A); mr(EXT, v); chk("R1 ext register", {24'd0, v}, 32'h5A);

        // R10: byte commands while off
        mw(D0, 8'h66); r0 = sclk_rises;
        docmd(8'hF2, n); chk("R10 send completes at once", {31'd0, n <= 2}, 1);
        docmd(8'hF3, n); chk("R10 read completes at once", {31'd0, n <= 2}, 1);
        docmd(8'hF0, n); chk("R10 cs ignored when off", {31'd0, spi_cs_n}, 1);
        chk("R10 no sclk while off", sclk_rises, r0);
        mr(D0, v); chk("R10 data0 untouched", {24'd0, v}, 32'h66);

        keyword("Start", v);    chk("R4 start before enter fails", {24'd0, v}, 32'hFE);
        keyword("End_Mode", v); chk("R5 exit from off is harmless", {24'd0, v}, 32'hAA);
        keyword("Bogus", v);    chk("R6 unknown keyword fails", {24'd0, v}, 32'hFE);
        keyword("Start", v);    chk("R6 mode stayed off", {24'd0, v}, 32'hFE);
        keyword("PathThruMode", v); chk("R3 enter keyword", {24'd0, v}, 32'hAA);
        keyword("Bogus", v);    chk("R6 unknown keyword while armed", {24'd0, v}, 32'hFE);
        keyword("Start", v);    chk("R4 start after enter", {24'd0, v}, 32'hAA);

        docmd(8'hF0, n); chk("R7 chip select asserted", {31'd0, spi_cs_n}, 0);

        // R2 busy write drop during an R8 send
        mw(D0, 8'hA5); exp_q.push_back(8'hA5); r0 = sclk_rises;
        mw(CMD, 8'hF2);
        hw(BASE, D0 + 8'd1); hw(DPORT, 8'h77);
        hw(BASE, CMD); hw(DPORT, 8'h33);
        wait_idle(n);
        mr(D0 + 8'd1, v); chk("R2 write dropped while busy", {24'd0, v}, 32'h74);
        chk("R8 eight rising edges", sclk_rises, r0 + 8);
        mr(D0, v); chk("R8 data0 kept after send", {24'd0, v}, 32'hA5);
        chk("R2 overwrite of command dropped", {31'd0, exp_q.size() == 0}, 1);

        mw(D0, 8'h5A); exp_q.push_back(8'h5A);
        docmd(8'hF2, n);
        chk("R11 clear after last edge", {31'd0, n >= 16*DIV + 1 && n <= 16*DIV + 4}, 1);

        slv_tx = 8'h3C; exp_q.push_back(8'h00);
        docmd(8'hF3, n); mr(D0, v); chk("R9 byte read into data0", {24'd0, v}, 32'h3C);

        foreach (exp_q[i]) ;
        for (int k = 0; k < 3; k++) begin
            logic [7:0] b;
            b = (k == 0) ? 8'h01 : (k == 1) ? 8'h80 : 8'hFF;
            mw(D0, b); exp_q.push_back(b); docmd(8'hF2, n);
        end
        slv_tx = 8'hC3; exp_q.push_back(8'h00);
        docmd(8'hF3, n); mr(D0, v); chk("R13 burst read", {24'd0, v}, 32'hC3);

        docmd(8'hF1, n); chk("R7 chip select released", {31'd0, spi_cs_n}, 1);
        docmd(8'hF0, n); chk("R7 chip select again", {31'd0, spi_cs_n}, 0);
        keyword("End_Mode", v); chk("R5 exit keyword", {24'd0, v}, 32'hAA);
        chk("R5 exit releases cs", {31'd0, spi_cs_n}, 1);
        r0 = sclk_rises;
        docmd(8'hF2, n); chk("R10 send after exit ignored", sclk_rises, r0);

        docmd(8'h85, n); chk("R12 smi cleared", {30'd0, smi_en, acpi_en}, 32'b01);
        docmd(8'h87, n); chk("R12 acpi cleared", {30'd0, smi_en, acpi_en}, 32'b00);
        docmd(8'h84, n); chk("R12 smi set", {30'd0, smi_en, acpi_en}, 32'b10);
        docmd(8'h86, n); chk("R12 acpi set", {30'd0, smi_en, acpi_en}, 32'b11);
        docmd(8'h12, n); chk("R2 unknown code quick", {31'd0, n <= 2}, 1);
        chk("R2 unknown code no effect", {30'd0, smi_en, acpi_en}, 32'b11);

        repeat (4) @(negedge clk);
        chk("R8 all expected bytes seen", exp_q.size(), 0);
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog R2 actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule